// File: doc/BRIEF.md
# Key Matrix Scanner with Press-Triggered Scanning

This block reads a matrix of up to thirty keys, wired as six drive lines crossed with five return lines. Each return line has a pull-down, so it reads low unless a closed key connects it to a drive line that is high. While no key is held, the block drives all six drive lines high at once and watches the OR of the returns. It does no per-line scanning in that state.

When any return goes high, the block walks the drive lines one at a time, starting with line 0. It holds each line for a fixed settle time and then samples the five returns into a 30-bit image. A new image is reported to the host only after two full scans in a row give the same non-zero result. At that point a ready flag is set, and it stays set until the host acknowledges it. One full scan that reads no key at all returns the block to its idle state and clears the reported vector and the flag.

A blanking input empties all key data, forces every drive line low and stops all scanning for as long as it is held.

Top module: `keyscan_top`

## Requirements
- R1: After reset, with blanking low, all drive lines are high, the key vector is zero and the ready flag is low.
- R2: While no key is closed and blanking is low, all six drive lines stay high together and no single-line drive pattern appears.
- R3: A high return seen while idle starts a scan. The scan drives exactly one line at a time, in the order line 0 to line 5, and holds each line for SETTLE clock cycles.
- R4: The key at drive line L and return input R is reported in key vector bit L*5+R, which gives bits 0 to 29.
- R5: A non-zero key vector is published, with the ready flag raised, only after two consecutive full scans give the same image. The earliest this can happen is two scan periods (2*6*SETTLE cycles) after the press.
- R6: The ready flag stays high, with the key vector stable, until the host pulses the acknowledge input for one cycle. The flag is low in the cycle after the acknowledge.
- R7: One full scan that reads all zeros returns the block to idle, with all drive lines high. It also clears the key vector to zero and drops the ready flag.
- R8: While blanking is high, the key vector is zero, the ready flag is low and all drive lines are low, even with keys closed. When blanking is released with keys still closed, the press is detected again and published again.
- R9: If the set of closed keys changes while keys stay held, the new image is published after two matching scans, and the flag is raised again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blank | input | 1 | High: clear key data, drive lines low, no scanning |
| ret_in | input | 5 | Return lines from the matrix, pulled down externally |
| ack | input | 1 | Host acknowledge, clears the ready flag |
| drv_out | output | 6 | Matrix drive lines |
| key_vec | output | 30 | Debounced key image, bit L*5+R |
| key_ready | output | 1 | A new key image is waiting for the host |

## Verification
The assertions assume that `blank` and `ack` are synchronous to `clk`. They also assume that a return line only goes high as an effect of the drive lines and the closed keys, so that a line appears one-hot during a scan and all-ones while idle. The bench keeps within these assumptions by deriving `ret_in` from a model of the matrix: each return is the OR of the driven lines whose key at that crossing is marked closed. It changes the closed-key set, `blank` and `ack` only on falling clock edges, so the settle window always contains stable returns.

// File: rtl/keyscan_pkg.sv
// keyscan_pkg: shared types for the key matrix scanner.
// Assumes: nothing beyond IEEE 1800-2017.
package keyscan_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,   // all drive lines high, waiting for any return
        ST_SCAN = 1'b1    // walking the drive lines one at a time
    } scan_state_t;
endpackage

// File: rtl/ks_line_seq.sv
// ks_line_seq: steps through the drive lines while run is high.
// Each line is held for SETTLE cycles. sample pulses in the last cycle of
// each hold, and last_sample marks that pulse for the final line.
// Assumes: SETTLE >= 4, so the synchronised returns settle inside a hold.
module ks_line_seq #(
    parameter int N_LINES = 6,
    parameter int SETTLE  = 4,
    localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int CW = $clog2(SETTLE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [LW-1:0] line,
    output logic          sample,
    output logic          last_sample
);
    logic [CW-1:0] hold_cnt;
    logic          hold_end;
    logic          line_end;

    assign hold_end    = (hold_cnt == CW'(SETTLE - 1));
    assign line_end    = (line == LW'(N_LINES - 1));
    assign sample      = run && hold_end;
    assign last_sample = sample && line_end;

    // Advance the hold counter and the line index; restart whenever run drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hold_cnt <= '0;
            line     <= '0;
        end else if (hold_end) begin
            hold_cnt <= '0;
            line     <= line_end ? '0 : line + 1'b1;
        end else begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // R3
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !last_sample && run) |=> (!run || line == LW'($past(line) + 1'b1)));

    // R3
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line < LW'(N_LINES));
endmodule

// File: rtl/ks_capture.sv
// ks_capture: assembles one full scan image from per-line samples.
// done pulses for one cycle, and vec is valid in that same cycle.
// Assumes: line and sample come from ks_line_seq.
module ks_capture #(
    parameter int N_LINES = 6,
    parameter int N_RET   = 5,
    localparam int NK = N_LINES * N_RET,
    localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             last_sample,
    input  logic [LW-1:0]    line,
    input  logic [N_RET-1:0] ret,
    output logic [NK-1:0]    vec,
    output logic             done
);
    logic [NK-1:0] img_q;

    for (genvar g = 0; g < N_LINES; g++) begin : g_slice
        // Store the returns of drive line g into bits g*N_RET and up.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                img_q[g*N_RET +: N_RET] <= '0;
            end else if (sample && line == LW'(g)) begin
                img_q[g*N_RET +: N_RET] <= ret;
            end
        end
    end

    // Flag a completed image one cycle after the last line is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            done <= 1'b0;
        end else begin
            done <= last_sample;
        end
    end

    assign vec = img_q;
endmodule

// File: rtl/ks_debounce.sv
// ks_debounce: publishes a key image after two identical consecutive scans
// and holds a ready flag until the host acknowledges it. An all-zero scan
// clears the published image.
// Assumes: scan_done is a one-cycle pulse, and scan_vec is valid with it.
module ks_debounce #(
    parameter int NK = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          scan_done,
    input  logic [NK-1:0] scan_vec,
    input  logic          ack,
    output logic [NK-1:0] key_vec,
    output logic          key_ready
);
    logic [NK-1:0] prev_q;
    logic          prev_ok;
    logic          any_key;
    logic          match;

    assign any_key = |scan_vec;
    assign match   = prev_ok && (scan_vec == prev_q);

    // Compare with the previous scan, publish on a match, and clear on release.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev_q    <= '0;
            prev_ok   <= 1'b0;
            key_vec   <= '0;
            key_ready <= 1'b0;
        end else if (scan_done) begin
            if (!any_key) begin
                prev_ok   <= 1'b0;
                key_vec   <= '0;
                key_ready <= 1'b0;
            end else begin
                prev_q  <= scan_vec;
                prev_ok <= 1'b1;
                if (match && scan_vec != key_vec) begin
                    key_vec   <= scan_vec;
                    key_ready <= 1'b1;
                end else if (ack) begin
                    key_ready <= 1'b0;
                end
            end
        end else if (ack) begin
            key_ready <= 1'b0;
        end
    end

    // R5
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_ready) |-> $past(scan_done));

    // R6
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_ready && !ack && !clear && !scan_done) |=> key_ready);

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_ready && ack && !clear && !scan_done) |=> !key_ready);

    // R8
    blank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (key_vec == '0 && !key_ready));
endmodule

// File: rtl/keyscan_top.sv
// keyscan_top: key matrix scanner. While idle it drives all lines high;
// a return seen high starts line-by-line scans, which continue until one
// scan reads no key. blank clears everything and stops all driving.
// Assumes: ret_in may be asynchronous and is synchronised here (2 flops).
module keyscan_top #(
    parameter int N_LINES = 6,
    parameter int N_RET   = 5,
    parameter int SETTLE  = 4,
    localparam int NK = N_LINES * N_RET,
    localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               blank,
    input  logic [N_RET-1:0]   ret_in,
    input  logic               ack,
    output logic [N_LINES-1:0] drv_out,
    output logic [NK-1:0]      key_vec,
    output logic               key_ready
);
    import keyscan_pkg::*;

    scan_state_t      state;
    logic [N_RET-1:0] ret_m, ret_s;
    logic             run;
    logic [LW-1:0]    line;
    logic             sample, last_sample;
    logic [NK-1:0]    scan_vec;
    logic             scan_done;

    // Bring the return lines into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_m <= '0;
            ret_s <= '0;
        end else begin
            ret_m <= ret_in;
            ret_s <= ret_m;
        end
    end

    // Idle/scan control: start on any return, stop after an empty scan.
    always_ff @(posedge clk) begin
        if (!rst_n || blank) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (|ret_s) state <= ST_SCAN;
                ST_SCAN: if (scan_done && scan_vec == '0) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign run = (state == ST_SCAN) && !blank;

    // Choose the drive pattern: off when blanked, all lines when idle, one line when scanning.
    always_comb begin
        if (blank)                 drv_out = '0;
        else if (state == ST_IDLE) drv_out = '1;
        else                       drv_out = N_LINES'(1) << line;
    end

    ks_line_seq #(.N_LINES(N_LINES), .SETTLE(SETTLE)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run),
        .line(line), .sample(sample), .last_sample(last_sample)
    );

    ks_capture #(.N_LINES(N_LINES), .N_RET(N_RET)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(blank),
        .sample(sample), .last_sample(last_sample), .line(line),
        .ret(ret_s), .vec(scan_vec), .done(scan_done)
    );

    ks_debounce #(.NK(NK)) u_deb (
        .clk(clk), .rst_n(rst_n), .clear(blank),
        .scan_done(scan_done), .scan_vec(scan_vec), .ack(ack),
        .key_vec(key_vec), .key_ready(key_ready)
    );

    // R3
    scan_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && !blank) |-> $onehot(drv_out));

    // R2
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !blank && ret_s == '0) |=> (blank || drv_out == '1));

    // R7
    release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done && scan_vec == '0 && !blank) |=> (state == ST_IDLE && key_vec == '0));

    // R8
    blank_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (state == ST_IDLE && !scan_done));
endmodule

// File: tb/tb_keyscan_top.sv
module tb_keyscan_top;
    localparam int NL = 6;
    localparam int NR = 5;
    localparam int ST = 4;
    localparam int NK = NL * NR;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          blank = 1'b0;
    logic          ack = 1'b0;
    logic [NR-1:0] ret;
    logic [NL-1:0] drv;
    logic [NK-1:0] key_vec;
    logic          key_ready;
    logic [NK-1:0] pressed = '0;

    int errors = 0;
    int checks = 0;
    logic [NK-1:0] exp_q[$];

    always #10 clk = ~clk;

    keyscan_top #(.N_LINES(NL), .N_RET(NR), .SETTLE(ST)) dut (
        .clk(clk), .rst_n(rst_n), .blank(blank), .ret_in(ret), .ack(ack),
        .drv_out(drv), .key_vec(key_vec), .key_ready(key_ready)
    );

    // Matrix model: a return is high if a driven line has a closed key on it.
    always_comb begin
        ret = '0;
        for (int l = 0; l < NL; l++)
            for (int r = 0; r < NR; r++)
                if (drv[l] && pressed[l*NR + r]) ret[r] = 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Monitor: every rising ready flag is compared with the next queued expectation.
    initial begin
        logic          prev_rdy;
        logic [NK-1:0] e;
        prev_rdy = 1'b0;
        forever begin
            @(negedge clk);
            if (key_ready && !prev_rdy) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected publish", 32'(key_vec), 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(key_vec == e, "R4", "published vector", 32'(key_vec), 32'(e));
                end
            end
            prev_rdy = key_ready;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R5", "watchdog expired", 32'h0, 32'h1);
        summary();
        $finish;
    end

    task automatic check_order();
        int  n;
        bit  ok;
        n = 0;
        while (drv == '1 && n < 100) begin
            @(negedge clk);
            n++;
        end
        for (int l = 0; l < NL; l++) begin
            ok = 1'b1;
            for (int c = 0; c < ST; c++) begin
                if (drv != NL'(1) << l) ok = 1'b0;
                if (!(l == NL-1 && c == ST-1)) @(negedge clk);
            end
            check(ok, "R3", "line drive order and hold", 32'(drv), 32'(NL'(1) << l));
        end
    endtask

    // Driver: close keys, queue the expectation, wait for it, then check hold and ack.
    task automatic press(input logic [NK-1:0] v, input bit order, input string req);
        int n;
        @(negedge clk);
        pressed = v;
        exp_q.push_back(v);
        n = 0;
        if (order) begin
            check_order();
            n = NL * ST;
        end
        while (exp_q.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, req, "publish happened", 32'(n), 32'h0);
        check(n >= 2 * NL * ST, "R5", "two scans before publish", 32'(n), 32'(2*NL*ST));
        repeat (40) @(negedge clk);
        check(key_ready && key_vec == v, "R6", "ready held until ack", 32'(key_ready), 32'h1);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(!key_ready, "R6", "ready cleared by ack", 32'(key_ready), 32'h0);
    endtask

    task automatic release_all();
        int n;
        @(negedge clk);
        pressed = '0;
        n = 0;
        while (drv != '1 && n < 500) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        check(drv == '1, "R7", "idle drive after release", 32'(drv), 32'h3f);
        check(key_vec == '0 && !key_ready, "R7", "vector cleared on release",
              32'(key_vec), 32'h0);
    endtask

    initial begin
        bit ok;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(drv == '1, "R1", "drive after reset", 32'(drv), 32'h3f);
        check(key_vec == '0 && !key_ready, "R1", "key data after reset", 32'(key_vec), 32'h0);

        // R2 idle with no keys
        ok = 1'b1;
        repeat (100) begin
            @(negedge clk);
            if (drv != '1 || key_ready) ok = 1'b0;
        end
        check(ok, "R2", "idle drive stays all high", 32'(drv), 32'h3f);

        // R3/R4 single key at line 0, return 0
        press(30'h0000_0001, 1'b1, "R4");
        release_all();
        // R4 last key: line 5, return 4
        press(30'h2000_0000, 1'b0, "R4");
        release_all();
        // R4 several keys across lines
        press(30'h15A5_0C31, 1'b1, "R4");
        // R9 change while held
        press(30'h0084_2108, 1'b0, "R9");

        // R8 blank clears and stops scanning
        @(negedge clk);
        blank = 1'b1;
        repeat (3) @(negedge clk);
        check(key_vec == '0 && !key_ready, "R8", "blank clears data", 32'(key_vec), 32'h0);
        ok = 1'b1;
        repeat (60) begin
            @(negedge clk);
            if (drv != '0 || key_vec != '0 || key_ready) ok = 1'b0;
        end
        check(ok, "R8", "no drive while blanked", 32'(drv), 32'h0);
        exp_q.push_back(30'h0084_2108);
        @(negedge clk);
        blank = 1'b0;
        repeat (300) @(negedge clk);
        check(exp_q.size() == 0, "R8", "republish after blank", 32'(exp_q.size()), 32'h0);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        release_all();

        // R2 idle again after release
        ok = 1'b1;
        repeat (60) begin
            @(negedge clk);
            if (drv != '1) ok = 1'b0;
        end
        check(ok, "R2", "idle after release", 32'(drv), 32'h3f);

        summary();
        $finish;
    end
endmodule